// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This unit watches two streams of processor activity and raises a debug request when a programmed condition is met. The first stream is data-bus accesses, each a valid strobe with an address and a data word. The second is retired instructions, each a valid strobe with a program counter. Thirteen 32-bit breakpoint registers describe the conditions: two inclusive address windows, two data patterns with don't-care masks, one PC pattern with a don't-care mask, and three exact PC values. A control register decides how the resulting match classes are combined.

Each cycle, three class hits are formed: address, data and PC. Each of the two trigger levels selects a subset of these classes and combines them with AND or OR. In single-level mode, a level-1 match requests a debug action. In two-level mode, a level-1 match only arms the unit, and a later level-2 match requests the action. The action is either a halt request or a debug-interrupt request, chosen by one control bit. All registers are loaded through one generic write port, which can be driven by an external debug channel or by privileged software.

Top module: `bkpt_trigger`

## Requirements
- R1: After reset, `halt_req`, `dbg_irq` and `armed` are 0, and every register, including control, is 0.
- R2: An address window hits when `bus_vld` is 1 and low ≤ `bus_addr` ≤ high, with both bounds inclusive. The address class is the OR of both windows and is 0 whenever `bus_vld` is 0.
- R3: A data pattern hits when `bus_vld` is 1 and `bus_data` equals the value in every bit whose mask bit is 0. A mask bit of 1 makes that bit don't-care. The data class is the OR of both patterns.
- R4: The PC class is 1 when `ret_vld` is 1 and either the masked PC compare holds (mask bit 1 = don't-care) or `ret_pc` exactly equals any of the three exact PC registers.
- R5: Control bits [2:0] select the level-1 classes and bits [6:4] select the level-2 classes (bit order: address, data, PC). Bit 3 (level 1) and bit 7 (level 2) choose AND (1) or OR (0) of the selected classes. A level with no class selected never matches.
- R6: With control bit 8 = 0 (single level), every cycle with a level-1 match produces a one-cycle request in the following cycle.
- R7: With control bit 8 = 1 (two level), a level-1 match while disarmed sets `armed` and issues no request, even if level 2 also matches in that cycle. A level-2 match while armed issues a request in the next cycle and clears `armed`. In single-level mode, `armed` stays 0.
- R8: Control bit 9 selects the action: 0 pulses `halt_req`, 1 pulses `dbg_irq`. The two are never high together.
- R9: A write to the control register clears `armed` and suppresses any request from that cycle.
- R10: Write indices are: 0/1 window 0 low/high, 2/3 window 1 low/high, 4/5 pattern 0 value/mask, 6/7 pattern 1 value/mask, 8 PC value, 9 PC mask, 10–12 exact PCs, 13 control (bits [9:0] kept). Writes to 14 and 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 32 | Register write data |
| bus_vld | input | 1 | Data-bus access valid |
| bus_addr | input | 32 | Access address |
| bus_data | input | 32 | Access data |
| ret_vld | input | 1 | Instruction retire valid |
| ret_pc | input | 32 | Retired instruction PC |
| halt_req | output | 1 | One-cycle halt request |
| dbg_irq | output | 1 | One-cycle debug-interrupt request |
| armed | output | 1 | Two-level sequence armed |

## Verification
The bench probes each window at its exact bounds and one step outside them. A design with strict instead of inclusive compares would miss a bound, and one with an off-by-one would fire just outside the window. It sets the level-1 and level-2 conditions true in the same cycle while disarmed; a design that lets level 2 act in the arming cycle would fire one access too early. It writes control during a hitting access; a design without the suppression would emit a stray request or keep a stale arm. Random streams aimed near the programmed values then cover the AND/OR and empty-selection combinations against a bench model. A design that inverts the mask polarity or drops the exact PC registers shows up there as mismatched pulses.

// File: rtl/bkpt_trigger.sv
module bkpt_trigger #(
  parameter int W      = 32,
  parameter int N_ADDR = 2,
  parameter int N_DATA = 2,
  parameter int N_PCX  = 3,
  parameter int RA_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic            bus_vld,
  input  logic [W-1:0]    bus_addr,
  input  logic [W-1:0]    bus_data,
  input  logic            ret_vld,
  input  logic [W-1:0]    ret_pc,
  output logic            halt_req,
  output logic            dbg_irq,
  output logic            armed
);
  localparam int DB   = 2 * N_ADDR;
  localparam int PB   = DB + 2 * N_DATA;
  localparam int XB   = PB + 2;
  localparam int CTL  = XB + N_PCX;
  localparam int NREG = CTL;
  localparam int CW   = 10;

  logic [W-1:0]  rf [NREG];
  logic [CW-1:0] ctl_q;
  logic [N_ADDR-1:0] a_hit;
  logic [N_DATA-1:0] d_hit;
  logic [N_PCX-1:0]  x_hit;
  logic [2:0] cls;
  logic ctl_wr, l1, l2, fire, pm_hit;

  for (genvar g = 0; g < N_ADDR; g++) begin : g_win
    assign a_hit[g] = (rf[2*g] <= bus_addr) && (bus_addr <= rf[2*g+1]);
  end
  for (genvar g = 0; g < N_DATA; g++) begin : g_pat
    assign d_hit[g] = ((bus_data ^ rf[DB+2*g]) & ~rf[DB+2*g+1]) == '0;
  end
  for (genvar g = 0; g < N_PCX; g++) begin : g_pcx
    assign x_hit[g] = ret_pc == rf[XB+g];
  end
  assign pm_hit = ((ret_pc ^ rf[PB]) & ~rf[PB+1]) == '0;

  assign cls = {ret_vld & (pm_hit | (|x_hit)), bus_vld & (|d_hit), bus_vld & (|a_hit)};

  function automatic logic lvl(input logic [2:0] en, input logic all_of, input logic [2:0] c);
    if (en == 3'b000) return 1'b0;
    return all_of ? ((c & en) == en) : |(c & en);
  endfunction

  assign l1     = lvl(ctl_q[2:0], ctl_q[3], cls);
  assign l2     = lvl(ctl_q[6:4], ctl_q[7], cls);
  assign ctl_wr = wr_en && (wr_addr == RA_W'(CTL));
  assign fire   = !ctl_wr && (ctl_q[8] ? (armed && l2) : l1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == RA_W'(CTL)) ctl_q <= wr_data[CW-1:0];
      else if (int'(wr_addr) < NREG) rf[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      halt_req <= 1'b0;
      dbg_irq  <= 1'b0;
    end else begin
      halt_req <= fire & ~ctl_q[9];
      dbg_irq  <= fire & ctl_q[9];
      if (ctl_wr || !ctl_q[8]) armed <= 1'b0;
      else if (armed)          armed <= !l2;
      else                     armed <= l1;
    end
  end
endmodule

// File: rtl/bkpt_trigger_chk.sv
module bkpt_trigger_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic       bus_vld,
  input logic       ret_vld,
  input logic       halt_req,
  input logic       dbg_irq,
  input logic       armed,
  input logic [9:0] ctl
);
  p_one_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && dbg_irq));

  p_action_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !$past(ctl[9]));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_vld && !ret_vld) |=> !(halt_req || dbg_irq));

  p_ctl_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd13) |=> (!armed && !halt_req && !dbg_irq));

  p_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) |-> ($past(armed) || !$past(ctl[8])));

  p_single_noarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[8] |=> !armed);
endmodule

bind bkpt_trigger bkpt_trigger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .bus_vld(bus_vld), .ret_vld(ret_vld), .halt_req(halt_req),
  .dbg_irq(dbg_irq), .armed(armed), .ctl(ctl_q)
);

// File: tb/test_bkpt_trigger.sv
module test_bkpt_trigger;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, bus_vld = 0, ret_vld = 0;
  logic [3:0] wr_addr = 0;
  logic [31:0] wr_data = 0, bus_addr = 0, bus_data = 0, ret_pc = 0;
  logic halt_req, dbg_irq, armed;

  int errors = 0, checks = 0;
  logic [31:0] m_reg [13];
  logic [9:0]  m_ctl;
  logic        m_armed;

  always #10 clk = ~clk;

  bkpt_trigger i_bkpt_trigger (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_vld(bus_vld), .bus_addr(bus_addr), .bus_data(bus_data),
    .ret_vld(ret_vld), .ret_pc(ret_pc),
    .halt_req(halt_req), .dbg_irq(dbg_irq), .armed(armed));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] classes(bit bv, logic [31:0] ba, logic [31:0] bd,
                                         bit rv, logic [31:0] rp);
    logic a = 0, d = 0, p = 0;
    for (int k = 0; k < 2; k++) begin
      if (ba >= m_reg[2*k] && ba <= m_reg[2*k+1]) a = 1;
      if ((bd & ~m_reg[5+2*k]) == (m_reg[4+2*k] & ~m_reg[5+2*k])) d = 1;
    end
    if ((rp | m_reg[9]) == (m_reg[8] | m_reg[9])) p = 1;
    for (int k = 10; k < 13; k++) if (rp == m_reg[k]) p = 1;
    return {rv & p, bv & d, bv & a};
  endfunction

  function automatic logic lv(logic [2:0] en, logic all_of, logic [2:0] c);
    if (en == 0) return 0;
    if (all_of) return (c & en) == en;
    return (c & en) != 0;
  endfunction

  task automatic step(string tag, bit we, int idx, logic [31:0] wd,
                      bit bv, logic [31:0] ba, logic [31:0] bd, bit rv, logic [31:0] rp);
    logic [2:0] c;
    logic l1, l2, cw, fire;
    @(negedge clk);
    wr_en = we; wr_addr = idx[3:0]; wr_data = wd;
    bus_vld = bv; bus_addr = ba; bus_data = bd; ret_vld = rv; ret_pc = rp;
    c  = classes(bv, ba, bd, rv, rp);
    l1 = lv(m_ctl[2:0], m_ctl[3], c);
    l2 = lv(m_ctl[6:4], m_ctl[7], c);
    cw = we && idx == 13;
    fire = !cw && (m_ctl[8] ? (m_armed && l2) : l1);
    if (cw || !m_ctl[8]) m_armed = 0;
    else if (m_armed) m_armed = !l2;
    else m_armed = l1;
    if (we && idx < 13) m_reg[idx] = wd;
    if (cw) m_ctl = wd[9:0];
    @(posedge clk); #5;
    chk({tag, " halt (R6 R8)"}, halt_req, fire & !m_ctl_prev(cw, wd));
    chk({tag, " irq (R8)"}, dbg_irq, fire & m_ctl_prev(cw, wd));
    chk({tag, " armed (R7)"}, armed, m_armed);
  endtask

  logic act_prev;
  function automatic logic m_ctl_prev(logic cw, logic [31:0] wd);
    if (cw) return wd[9] ^ wd[9] ^ act_prev;
    return m_ctl[9];
  endfunction

  task automatic wr(int idx, logic [31:0] v);
    act_prev = m_ctl[9];
    step("R10 write", 1, idx, v, 0, 0, 0, 0, 0);
  endtask

  task automatic bus(string tag, logic [31:0] a, logic [31:0] d);
    act_prev = m_ctl[9];
    step(tag, 0, 0, 0, 1, a, d, 0, 0);
  endtask

  task automatic ret(string tag, logic [31:0] p);
    act_prev = m_ctl[9];
    step(tag, 0, 0, 0, 0, 0, 0, 1, p);
  endtask

  task automatic clear_all();
    for (int k = 0; k < 13; k++) wr(k, 32'hFFFF_FFF0);
    wr(1, 0); wr(3, 0); wr(5, 0); wr(7, 0); wr(9, 0);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 13; k++) m_reg[k] = 0;
    m_ctl = 0; m_armed = 0; act_prev = 0;
    #35;
    chk("R1 halt reset", halt_req, 0);
    chk("R1 irq reset", dbg_irq, 0);
    chk("R1 armed reset", armed, 0);
    rst_n = 1;
    ret("R1 all-zero PC with no class enabled", 0);

    clear_all();
    wr(0, 32'h100); wr(1, 32'h1FF);
    wr(13, 32'h001);
    bus("R2 low bound", 32'h100, 0);
    bus("R2 high bound", 32'h1FF, 0);
    bus("R2 below", 32'hFF, 0);
    bus("R2 above", 32'h200, 0);
    act_prev = m_ctl[9];
    step("R2 strobe low", 0, 0, 0, 0, 32'h150, 0, 0, 0);
    wr(14, 32'h0); wr(15, 32'hFFFF_FFFF);
    bus("R10 unused index ignored", 32'h150, 0);

    wr(4, 32'hA5A5_0000); wr(5, 32'h0000_FFFF); wr(13, 32'h002);
    bus("R3 masked hit", 32'h0, 32'hA5A5_1234);
    bus("R3 miss", 32'h0, 32'hA5A4_0000);

    wr(8, 32'h4000); wr(9, 32'hF); wr(10, 32'h8000); wr(13, 32'h004);
    ret("R4 masked pc hit", 32'h400C);
    ret("R4 masked pc miss", 32'h4010);
    ret("R4 exact hit", 32'h8000);
    ret("R4 exact miss", 32'h8004);

    wr(13, 32'h00D);
    bus("R5 AND partial", 32'h150, 0);
    act_prev = m_ctl[9];
    step("R5 AND both", 0, 0, 0, 1, 32'h150, 0, 1, 32'h8000);
    wr(13, 32'h300);
    act_prev = m_ctl[9];
    step("R5 nothing selected", 0, 0, 0, 1, 32'h150, 32'hA5A5_0000, 1, 32'h8000);

    wr(13, 32'h201);
    bus("R8 interrupt action", 32'h150, 0);

    wr(13, 32'h114);
    act_prev = m_ctl[9];
    step("R7 arm cycle both levels", 0, 0, 0, 1, 32'h150, 0, 1, 32'h8000);
    bus("R7 level2 fires", 32'h150, 0);
    bus("R7 disarmed after fire", 32'h150, 0);
    ret("R7 rearm", 32'h8000);
    act_prev = m_ctl[9];
    step("R9 ctl write suppresses", 1, 13, 32'h114, 1, 32'h150, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      act_prev = m_ctl[9];
      if (r < 3) begin
        v = $urandom;
        step("R5 random ctl", 1, 13, v, 1, m_reg[$urandom % 4], $urandom, 1, m_reg[10]);
      end else if (r < 6) begin
        int idx = int'($urandom % 13);
        v = (idx == 5 || idx == 7 || idx == 9) ? ($urandom & 32'h0000_00FF) : ($urandom & 32'h0000_0FFF);
        step("R10 random reg", 1, idx, v, 0, 0, 0, 0, 0);
      end else begin
        logic [31:0] ba, bd, rp;
        ba = m_reg[$urandom % 4] + 32'($urandom % 3) - 32'd1;
        bd = m_reg[4 + 2 * ($urandom % 2)] ^ (($urandom % 2) ? 32'h0 : 32'(1 << ($urandom % 12)));
        rp = ($urandom % 2) ? m_reg[8 + ($urandom % 5)] : (m_reg[8] ^ 32'($urandom % 4));
        step("R6 random", 0, 0, 0, ($urandom % 4) != 0, ba, bd, ($urandom % 3) != 0, rp);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule